// File: doc/BRIEF.md
# Master Clock to Frame Clock Ratio Detector

This block lives in the master clock domain of an audio converter. It watches a left/right frame clock that is synchronous to the master clock. The master clock must run at 256, 384 or 512 times the frame rate. The block works out which of the three ratios is present by counting master clock cycles from one rising frame edge to the next. Once two periods in a row agree on a legal ratio, it reports a 2-bit ratio code with a valid flag.

While locked, the block checks every frame period against the locked length. An edge that arrives early, or no edge by the time the locked count is reached, is treated as a broken clock relationship. The block then pulses a reset request, drops the valid flag and starts detecting again.

While locked it also drives two timing outputs for later filter and modulator stages:
- a one-cycle frame pulse for each good period;
- a divider strobe once every ratio/64 master cycles, phase-aligned to the frame.

Top module: `mclk_ratio_detect`

## Requirements
- R1: During and right after reset, ratio_valid, reset_req, frame_pulse and div_strobe are 0 and ratio_code is 2'b00.
- R2: A period is the number of clk cycles between two consecutive frame_clk rising edges. Only periods of exactly 256, 384 or 512 are legal.
- R3: When unlocked, ratio_valid rises after two consecutive legal periods of equal length. It rises two clk edges after the edge at which frame_clk is first sampled high at the end of the second period.
- R4: ratio_code is 2'b00 for 256, 2'b01 for 384 and 2'b10 for 512. It reads 2'b00 whenever ratio_valid is 0.
- R5: An illegal period discards the pending candidate, so a legal period before it and an equal one after it do not lock.
- R6: Two consecutive legal periods of different length do not lock. The later one becomes the new candidate.
- R7: While locked, a rising edge that ends a period shorter than the locked length causes the following:
  - a reset_req pulse lasting exactly one cycle;
  - ratio_valid drops on the same edge;
  - that rising edge starts the next measurement.
- R8: While locked, if the count reaches the locked length with no rising edge, reset_req pulses and ratio_valid drops at that point. Detection then waits for a fresh rising edge before it measures.
- R9: While locked, each period of exactly the locked length yields a one-cycle frame_pulse. The pulse comes two clk edges after the edge that samples frame_clk high.
- R10: While locked, div_strobe pulses every ratio/64 cycles, counted from the edge at which ratio_valid rose. Every 64th strobe coincides with frame_pulse. No strobe is issued on a cycle that raises reset_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Left/right frame clock, synchronous to clk |
| ratio_code | output | 2 | Detected ratio code (see R4) |
| ratio_valid | output | 1 | Ratio locked |
| reset_req | output | 1 | One-cycle request to reset downstream logic |
| frame_pulse | output | 1 | One pulse per good locked frame period |
| div_strobe | output | 1 | Divider enable every ratio/64 cycles |

## Verification
The frame pulse and the last divider strobe of a period are meant to fall in the same cycle. A mismatch edge must suppress both of them while it raises the reset request. The bench provokes the coincidence by running locked streams at all three ratios, and provokes the suppression with early edges (periods of 100, 200 and 300 cycles) and a late edge (500 after a 384 lock). A behavioural model predicts all five outputs on every clock, with strobe timing taken as a modulo count from the lock edge. Each cycle is judged by comparing the model's prediction with the block's outputs.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

   localparam int unsigned NUM_RATIOS = 3;
   localparam int unsigned CODE_W     = 2;

   typedef enum logic [CODE_W-1:0] {
      RC_LOW  = 2'b00,
      RC_MID  = 2'b01,
      RC_HIGH = 2'b10,
      RC_NONE = 2'b11
   } ratio_code_t;

   typedef enum logic [1:0] {
      ST_SEEK    = 2'b00,
      ST_MEASURE = 2'b01,
      ST_LOCKED  = 2'b10
   } lock_state_t;

endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_clk,
   output logic rise
);

   logic samp_now;
   logic samp_old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_now <= 1'b0;
         samp_old <= 1'b0;
      end else begin
         samp_now <= frame_clk;
         samp_old <= samp_now;
      end
   end

   assign rise = samp_now & ~samp_old;

endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (rise) begin
         count <= CNT_ONE;
      end else if (count != CNT_MAX) begin
         count <= count + CNT_ONE;
      end
   end

endmodule

// File: rtl/mrd_ratio_classifier.sv
module mrd_ratio_classifier
   import mrd_pkg::*;
#(
   parameter int unsigned CNT_W   = 10,
   parameter int unsigned RATIO_A = 256,
   parameter int unsigned RATIO_B = 384,
   parameter int unsigned RATIO_C = 512
) (
   input  logic [CNT_W-1:0] period,
   output logic             legal,
   output ratio_code_t      code
);

   localparam int unsigned RATIOS [NUM_RATIOS] = '{RATIO_A, RATIO_B, RATIO_C};

   logic [NUM_RATIOS-1:0] hit;

   for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_cmp
      assign hit[g] = (period == CNT_W'(RATIOS[g]));
   end

   always_comb begin
      code = RC_NONE;
      for (int i = 0; i < NUM_RATIOS; i++) begin
         if (hit[i]) code = ratio_code_t'(i);
      end
   end

   assign legal = |hit;

endmodule

// File: rtl/mrd_lock_ctrl.sv
module mrd_lock_ctrl
   import mrd_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic [CNT_W-1:0] count,
   input  logic             legal,
   input  ratio_code_t      code,
   output logic             locked,
   output ratio_code_t      lock_code,
   output logic [CNT_W-1:0] lock_len,
   output logic             mismatch,
   output logic             reset_req,
   output logic             frame_pulse
);

   lock_state_t state;
   ratio_code_t cand;
   logic        cand_v;

   // A locked period is broken when an edge and the expected count disagree:
   // an early edge, or the count reaching the length with no edge.
   always_comb begin
      mismatch = (state == ST_LOCKED) && (rise != (count == lock_len));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_SEEK;
         cand        <= RC_NONE;
         cand_v      <= 1'b0;
         lock_code   <= RC_LOW;
         lock_len    <= '0;
         reset_req   <= 1'b0;
         frame_pulse <= 1'b0;
      end else begin
         reset_req   <= 1'b0;
         frame_pulse <= 1'b0;
         unique case (state)
            ST_SEEK: begin
               if (rise) state <= ST_MEASURE;
            end
            ST_MEASURE: begin
               if (rise) begin
                  if (legal && cand_v && (cand == code)) begin
                     state     <= ST_LOCKED;
                     lock_code <= code;
                     lock_len  <= count;
                  end else begin
                     cand   <= code;
                     cand_v <= legal;
                  end
               end
            end
            ST_LOCKED: begin
               if (mismatch) begin
                  reset_req <= 1'b1;
                  cand_v    <= 1'b0;
                  state     <= rise ? ST_MEASURE : ST_SEEK;
               end else if (rise) begin
                  frame_pulse <= 1'b1;
               end
            end
            default: state <= ST_SEEK;
         endcase
      end
   end

   assign locked = (state == ST_LOCKED);

endmodule

// File: rtl/mrd_strobe_div.sv
module mrd_strobe_div #(
   parameter int unsigned CNT_W     = 10,
   parameter int unsigned DIV_SHIFT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             locked,
   input  logic             mismatch,
   input  logic [CNT_W-1:0] lock_len,
   output logic             strobe
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] step;
   logic [CNT_W-1:0] phase;
   logic             at_step;

   assign step    = lock_len >> DIV_SHIFT;
   assign at_step = (phase == step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= CNT_ONE;
         strobe <= 1'b0;
      end else begin
         if (!locked || at_step) phase <= CNT_ONE;
         else                    phase <= phase + CNT_ONE;
         strobe <= locked && !mismatch && at_step;
      end
   end

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
   import mrd_pkg::*;
#(
   parameter int unsigned CNT_W     = 10,
   parameter int unsigned RATIO_A   = 256,
   parameter int unsigned RATIO_B   = 384,
   parameter int unsigned RATIO_C   = 512,
   parameter int unsigned DIV_SHIFT = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_clk,
   output logic [1:0] ratio_code,
   output logic       ratio_valid,
   output logic       reset_req,
   output logic       frame_pulse,
   output logic       div_strobe
);

   localparam int unsigned DIV_UNIT = 1 << DIV_SHIFT;

   if ((1 << CNT_W) <= RATIO_C) begin : g_bad_width
      $error("CNT_W too narrow for largest ratio");
   end
   if (!(RATIO_A < RATIO_B && RATIO_B < RATIO_C)) begin : g_bad_order
      $error("ratios must be strictly ascending");
   end
   if ((RATIO_A % DIV_UNIT) != 0 || (RATIO_B % DIV_UNIT) != 0 ||
       (RATIO_C % DIV_UNIT) != 0) begin : g_bad_div
      $error("ratios must be multiples of the divider unit");
   end

   logic             rise;
   logic [CNT_W-1:0] count;
   logic             legal;
   ratio_code_t      code;
   logic             locked;
   ratio_code_t      lock_code;
   logic [CNT_W-1:0] lock_len;
   logic             mismatch;

   mrd_edge_sync u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_clk (frame_clk),
      .rise      (rise)
   );

   mrd_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .rise  (rise),
      .count (count)
   );

   mrd_ratio_classifier #(
      .CNT_W   (CNT_W),
      .RATIO_A (RATIO_A),
      .RATIO_B (RATIO_B),
      .RATIO_C (RATIO_C)
   ) u_cls (
      .period (count),
      .legal  (legal),
      .code   (code)
   );

   mrd_lock_ctrl #(.CNT_W(CNT_W)) u_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .rise        (rise),
      .count       (count),
      .legal       (legal),
      .code        (code),
      .locked      (locked),
      .lock_code   (lock_code),
      .lock_len    (lock_len),
      .mismatch    (mismatch),
      .reset_req   (reset_req),
      .frame_pulse (frame_pulse)
   );

   mrd_strobe_div #(.CNT_W(CNT_W), .DIV_SHIFT(DIV_SHIFT)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .locked   (locked),
      .mismatch (mismatch),
      .lock_len (lock_len),
      .strobe   (div_strobe)
   );

   assign ratio_valid = locked;
   assign ratio_code  = locked ? lock_code : RC_LOW;

endmodule

// File: rtl/mrd_checker.sv
module mrd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] ratio_code,
   input logic       ratio_valid,
   input logic       reset_req,
   input logic       frame_pulse,
   input logic       div_strobe
);

   // R7
   rst_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);

   // R7
   valid_drop_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> !ratio_valid);

   // R8
   req_only_from_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reset_req) |-> $past(ratio_valid));

   // R4
   code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_valid |-> (ratio_code != 2'b11));

   // R4
   code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ratio_valid |-> (ratio_code == 2'b00));

   // R9
   pulse_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |-> (ratio_valid && !reset_req));

   // R10
   strobe_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |-> div_strobe);

   // R10
   strobe_not_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> !div_strobe);

   // R3
   code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_valid && $past(ratio_valid)) |-> $stable(ratio_code));

endmodule

bind mclk_ratio_detect mrd_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ratio_code  (ratio_code),
   .ratio_valid (ratio_valid),
   .reset_req   (reset_req),
   .frame_pulse (frame_pulse),
   .div_strobe  (div_strobe)
);

// File: tb/mclk_ratio_detect_test.sv
`timescale 1ns/1ps
module mclk_ratio_detect_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_clk = 1'b0;
   logic [1:0] ratio_code;
   logic       ratio_valid, reset_req, frame_pulse, div_strobe;

   int nchk = 0;
   int nfail = 0;
   int req_seen = 0;

   always #4 clk = ~clk;

   mclk_ratio_detect uut (
      .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
      .ratio_code(ratio_code), .ratio_valid(ratio_valid),
      .reset_req(reset_req), .frame_pulse(frame_pulse), .div_strobe(div_strobe)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: edge times kept as cycle numbers.
   int cyc, m_last, m_cand, m_lockp, m_lockedge;
   bit h1, h2, m_armed, m_locked;
   bit e_valid, e_rst, e_fp, e_ds;
   int e_code;

   function automatic int code_of(input int p);
      return (p == 256) ? 0 : (p == 384) ? 1 : (p == 512) ? 2 : -1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc = 0; m_last = 0; m_cand = -1; m_lockp = 0; m_lockedge = 0;
         h1 = 0; h2 = 0; m_armed = 0; m_locked = 0;
         e_valid = 0; e_rst = 0; e_fp = 0; e_ds = 0; e_code = 0;
      end else begin
         automatic bit r = h1 && !h2;
         automatic int gap = cyc - m_last;
         automatic bit bad = 0;
         cyc++;
         gap = cyc - m_last;
         e_rst = 0; e_fp = 0; e_ds = 0;
         if (m_locked) begin
            bad = (r != (gap == m_lockp));
            e_fp = r && !bad;
            e_ds = !bad && (((cyc - m_lockedge) % (m_lockp / 64)) == 0);
            if (bad) begin
               e_rst = 1; m_locked = 0; m_cand = -1; m_armed = r;
            end
         end else if (r) begin
            if (m_armed) begin
               if (code_of(gap) >= 0 && m_cand == gap) begin
                  m_locked = 1; m_lockp = gap; m_lockedge = cyc;
               end else begin
                  m_cand = (code_of(gap) >= 0) ? gap : -1;
               end
            end
            m_armed = 1;
         end
         if (r) m_last = cyc;
         e_valid = m_locked;
         e_code = m_locked ? code_of(m_lockp) : 0;
         h2 = h1; h1 = frame_clk;
      end
   end

   always @(negedge clk) begin
      chk(ratio_valid == e_valid, "R3 ratio_valid", ratio_valid, e_valid);
      chk(ratio_code == e_code[1:0], "R4 ratio_code", ratio_code, e_code);
      chk(reset_req == e_rst, "R7 reset_req", reset_req, e_rst);
      chk(frame_pulse == e_fp, "R9 frame_pulse", frame_pulse, e_fp);
      chk(div_strobe == e_ds, "R10 div_strobe", div_strobe, e_ds);
      if (reset_req) req_seen++;
   end

   task automatic frame(input int len);
      @(negedge clk) frame_clk = 1'b1;
      repeat (len / 2 - 1) @(negedge clk);
      @(negedge clk) frame_clk = 1'b0;
      repeat (len - len / 2 - 1) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++; nchk++;
      $display("FAIL watchdog actual=200000 expected<200000 cycles");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!ratio_valid && !reset_req && !frame_pulse && !div_strobe && ratio_code == 0,
          "R1 reset state", {ratio_code, ratio_valid, reset_req, frame_pulse, div_strobe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ratio_valid && ratio_code == 0, "R1 after release", ratio_valid, 0);

      // 256 lock
      repeat (4) frame(256);
      chk(ratio_valid && ratio_code == 2'b00, "R2 lock 256", ratio_code, 0);
      // early edge, then 384
      frame(200);
      repeat (3) frame(384);
      chk(req_seen == 1, "R7 early edge request", req_seen, 1);
      chk(ratio_valid && ratio_code == 2'b01, "R4 lock 384", ratio_code, 1);
      // late edge, then 512
      frame(500);
      repeat (3) frame(512);
      chk(req_seen == 2, "R8 late edge request", req_seen, 2);
      chk(ratio_valid && ratio_code == 2'b10, "R4 lock 512", ratio_code, 2);
      // alternating legal periods
      frame(300);
      frame(256); frame(384); frame(256); frame(384);
      chk(!ratio_valid, "R6 alternating no lock", ratio_valid, 0);
      frame(384); frame(384);
      chk(ratio_valid && ratio_code == 2'b01, "R6 relock 384", ratio_code, 1);
      // illegal period between equal legal ones
      frame(100); frame(256); frame(1000); frame(256); frame(256);
      chk(!ratio_valid, "R5 illegal clears candidate", ratio_valid, 0);
      frame(256); frame(256);
      chk(ratio_valid && ratio_code == 2'b00, "R5 relock 256", ratio_code, 0);
      chk(req_seen == 4, "R8 total requests", req_seen, 4);
      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule